// File: doc/BRIEF.md
# Card Command Response Decoder

This block finishes the host side of one command exchange with a memory card. The host supplies the command index, the response kind it expected, a busy hint, an init-sequence flag, the number of response bytes actually captured and a 16-byte capture buffer. The block then decides whether the response arrived in full. For status-bearing responses it tests the card status against an error mask chosen by the response kind. It produces the status flag updates for the host controller and loads the captured bytes into eight 16-bit response registers.

One request is presented as a single-cycle `req_valid` pulse. One cycle later `done` pulses for one cycle. In that same cycle `stat_set` and `stat_clr` carry the bits that the controller's status register must set or clear. The response registers take their new value on the same clock edge that raises `done`. Status bit meanings:
- bit 0: command complete
- bit 2: stop complete
- bit 7: response timeout
- bit 12: card busy
- bit 14: card error

Top module: `rsp_decoder`

## Requirements
- R1: A request with `init_seq` high and command index 0 yields `stat_set` = 0x0001 and `stat_clr` = 0, and leaves the response registers unchanged.
- R2: The response kind is encoded on `rsp_kind` as follows: 0 none, 1 normal, 2 long, 3 OCR, 4 RCA, and 5 to 7 behave as none. A normal response with `busy` high is decoded exactly as a normal response.
- R3: Normal, OCR and RCA responses need `rsp_len` >= 4, and long responses need `rsp_len` >= 16. A shorter response is a timeout. A timeout sets bit 7, clears bit 14, does not set bits 0, 2 or 12, and leaves the response registers unchanged.
- R4: For a normal response the checked value is {byte0,byte1,byte2,byte3}, where byte i is `rsp_bytes[8i+7:8i]`. The error mask is 0xFDF90000, and 0x00000008 is added to it when `auth_en` is high.
- R5: For a complete OCR response, bit 12 is set when bit 31 of {byte0,byte1,byte2,byte3} is clear.
- R6: For an RCA response the checked value is {byte2,byte3} and the mask is 0xE008, independent of `auth_en`.
- R7: When the checked value ANDed with the mask is non-zero, bit 14 is set. Otherwise bit 14 is cleared. Long and OCR responses never flag an error. `stat_set` and `stat_clr` never share a bit.
- R8: On a complete, non-none response, register r (`rsp_regs[16r+15:16r]`) receives {byte(14-2r), byte(15-2r)}.
- R9: Without a timeout, command index 12 sets bits 0 and 2, and any other index sets bit 0 only.
- R10: A none-kind response never times out, whatever `rsp_len` is, and leaves the response registers unchanged.
- R11: `done` pulses exactly one cycle after `req_valid`. Outside a `done` cycle, `stat_set` and `stat_clr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Completed exchange presented this cycle |
| cmd_idx | input | 6 | Command index |
| rsp_kind | input | 3 | Expected response kind |
| busy | input | 1 | Busy-signalling variant requested |
| init_seq | input | 1 | Request is part of the init sequence |
| auth_en | input | 1 | Card-mode flag adding the authentication error bit |
| rsp_len | input | 5 | Response bytes captured (0 to 16) |
| rsp_bytes | input | 128 | Capture buffer, byte i at bits 8i+7:8i |
| done | output | 1 | Decode result valid |
| stat_set | output | 16 | Status bits to set |
| stat_clr | output | 16 | Status bits to clear |
| rsp_regs | output | 128 | Eight response registers, register r at bits 16r+15:16r |

## Verification
A faulty length threshold or mask shows up at the `done` pulse of the very request that uses it. It appears as a wrong bit 7 or bit 14 in `stat_set`/`stat_clr`. A wrong byte or word order in the response registers is visible in the cycle right after `done`, because the registers hold that value until the next load. Registers that load when they should not are caught on the next timeout, none-kind or init request, because the previously loaded contents must survive it. The stimulus mixes random buffers, lengths around the thresholds and every kind, including the undefined kind codes.

// File: rtl/rsp_decoder.sv
module rsp_decoder #(
  parameter int CMD_W    = 6,
  parameter int STOP_CMD = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  cmd_idx,
  input  logic [2:0]        rsp_kind,
  input  logic              busy,
  input  logic              init_seq,
  input  logic              auth_en,
  input  logic [4:0]        rsp_len,
  input  logic [127:0]      rsp_bytes,
  output logic              done,
  output logic [15:0]       stat_set,
  output logic [15:0]       stat_clr,
  output logic [127:0]      rsp_regs
);
  localparam logic [2:0]  K_NORM = 3'd1;
  localparam logic [2:0]  K_LONG = 3'd2;
  localparam logic [2:0]  K_OCR  = 3'd3;
  localparam logic [2:0]  K_RCA  = 3'd4;
  localparam logic [31:0] NORM_MASK = 32'hFDF9_0000;
  localparam logic [31:0] AUTH_BIT  = 32'h0000_0008;
  localparam logic [31:0] RCA_MASK  = 32'h0000_E008;

  logic        is_norm, is_none, short_rsp, err, init0, load;
  logic [4:0]  need_len;
  logic [31:0] word32, chk, mask;
  logic [15:0] set_n, clr_n;
  logic [127:0] regs_n;

  assign word32  = {rsp_bytes[7:0], rsp_bytes[15:8], rsp_bytes[23:16], rsp_bytes[31:24]};
  assign is_norm = (rsp_kind == K_NORM) || (busy && rsp_kind == K_NORM);
  assign is_none = (rsp_kind == 3'd0) || (rsp_kind > K_RCA);
  assign need_len = (rsp_kind == K_LONG) ? 5'd16 : (is_none ? 5'd0 : 5'd4);
  assign short_rsp = rsp_len < need_len;
  assign init0 = init_seq && (cmd_idx == '0);
  assign load  = !init0 && !is_none && !short_rsp;

  always_comb begin
    chk  = '0;
    mask = '0;
    if (is_norm) begin
      chk  = word32;
      mask = NORM_MASK | (auth_en ? AUTH_BIT : 32'h0);
    end else if (rsp_kind == K_RCA) begin
      chk  = {16'h0, word32[15:0]};
      mask = RCA_MASK;
    end
  end

  assign err = !short_rsp && |(chk & mask);

  always_comb begin
    set_n = '0;
    clr_n = '0;
    if (init0) begin
      set_n[0] = 1'b1;
    end else begin
      set_n[14] = err;
      clr_n[14] = !err;
      set_n[7]  = short_rsp;
      set_n[0]  = !short_rsp;
      set_n[2]  = !short_rsp && (int'(cmd_idx) == STOP_CMD);
      set_n[12] = !short_rsp && (rsp_kind == K_OCR) && !word32[31];
    end
  end

  for (genvar r = 0; r < 8; r++) begin : g_word
    assign regs_n[16*r +: 16] = {rsp_bytes[8*(14-2*r) +: 8], rsp_bytes[8*(15-2*r) +: 8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      stat_set <= '0;
      stat_clr <= '0;
      rsp_regs <= '0;
    end else begin
      done     <= req_valid;
      stat_set <= req_valid ? set_n : '0;
      stat_clr <= req_valid ? clr_n : '0;
      if (req_valid && load) rsp_regs <= regs_n;
    end
  end
endmodule

module rsp_decoder_chk #(
  parameter int CMD_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [CMD_W-1:0] cmd_idx,
  input logic [2:0]       rsp_kind,
  input logic             init_seq,
  input logic             done,
  input logic [15:0]      stat_set,
  input logic [15:0]      stat_clr,
  input logic [127:0]     rsp_regs
);
  a_r11_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (stat_set == '0 && stat_clr == '0));
  a_r7_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((stat_set & stat_clr) == '0));
  a_r3_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(stat_set[7] && stat_set[0]));
  a_r10_none_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (rsp_kind == 3'd0 || rsp_kind > 3'd4)) |=> $stable(rsp_regs));
  a_r1_init_only_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && init_seq && cmd_idx == '0) |=> (stat_set == 16'h0001 && stat_clr == '0 && $stable(rsp_regs)));
endmodule

bind rsp_decoder rsp_decoder_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd_idx(cmd_idx),
  .rsp_kind(rsp_kind), .init_seq(init_seq), .done(done),
  .stat_set(stat_set), .stat_clr(stat_clr), .rsp_regs(rsp_regs)
);

// File: tb/rsp_decoder_tb.sv
module rsp_decoder_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [5:0]   cmd_idx = '0;
  logic [2:0]   rsp_kind = '0;
  logic         busy = 1'b0;
  logic         init_seq = 1'b0;
  logic         auth_en = 1'b0;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_bytes = '0;
  logic         done;
  logic [15:0]  stat_set, stat_clr;
  logic [127:0] rsp_regs;

  int checks = 0;
  int fails = 0;
  logic [127:0] exp_regs = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  rsp_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cmd_idx(cmd_idx),
    .rsp_kind(rsp_kind), .busy(busy), .init_seq(init_seq), .auth_en(auth_en),
    .rsp_len(rsp_len), .rsp_bytes(rsp_bytes), .done(done),
    .stat_set(stat_set), .stat_clr(stat_clr), .rsp_regs(rsp_regs)
  );

  function automatic logic [7:0] byt(input logic [127:0] b, input int i);
    return b[8*i +: 8];
  endfunction

  // Model from R1..R10: returns {set, clr}, and whether the registers load
  function automatic logic [32:0] model(input logic [5:0] c, input logic [2:0] k,
      input logic ini, input logic au, input logic [4:0] len, input logic [127:0] b);
    logic [15:0] s, cl;
    logic [31:0] w, v, m;
    int need;
    logic none, tmo, ld;
    s = '0; cl = '0;
    w = {byt(b,0), byt(b,1), byt(b,2), byt(b,3)};
    none = (k == 0) || (k > 4);
    need = (k == 2) ? 16 : (none ? 0 : 4);
    tmo = int'(len) < need;
    if (ini && c == 0) begin
      s = 16'h0001; ld = 0;
    end else begin
      v = 0; m = 0;
      if (k == 1) begin v = w; m = 32'hFDF90000 | (au ? 32'h8 : 32'h0); end
      if (k == 4) begin v = {16'h0, byt(b,2), byt(b,3)}; m = 32'hE008; end
      if (!tmo && (v & m) != 0) s[14] = 1; else cl[14] = 1;
      if (tmo) s[7] = 1;
      else begin
        s[0] = 1;
        if (c == 12) s[2] = 1;
        if (k == 3 && !w[31]) s[12] = 1;
      end
      ld = !none && !tmo;
    end
    return {ld, s, cl};
  endfunction

  function automatic logic [127:0] regs_of(input logic [127:0] b);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) r[16*(7-k) +: 16] = {byt(b,2*k), byt(b,2*k+1)};
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [5:0] c, input logic [2:0] k,
      input logic bz, input logic ini, input logic au, input logic [4:0] len,
      input logic [127:0] b);
    logic [32:0] e;
    e = model(c, k, ini, au, len, b);
    @(negedge clk);
    cmd_idx = c; rsp_kind = k; busy = bz; init_seq = ini; auth_en = au;
    rsp_len = len; rsp_bytes = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (e[32]) exp_regs = regs_of(b);
    chk({req, " R11 done"}, {127'b0, done}, 128'd1);
    chk({req, " set"}, {112'b0, stat_set}, {112'b0, e[31:16]});
    chk({req, " clr"}, {112'b0, stat_clr}, {112'b0, e[15:0]});
    chk({req, " R8 regs"}, rsp_regs, exp_regs);
    @(negedge clk);
    chk({req, " R11 quiet"}, {95'b0, done, stat_set, stat_clr}, 128'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] pat;
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    pat = 128'h0F0E0D0C0B0A09080706050403020100;
    repeat (3) @(negedge clk);
    chk("reset", {95'b0, done, stat_set, stat_clr}, 128'd0);
    chk("reset regs", rsp_regs, 128'd0);
    rst_n = 1'b1;
    issue("R8 order", 6'd17, 3'd1, 0, 0, 0, 5'd16, pat);
    issue("R1 init cmd0", 6'd0, 3'd1, 0, 1, 0, 5'd16, ~pat);
    issue("R1 init cmd5 normal", 6'd5, 3'd1, 0, 1, 0, 5'd4, {96'h0, 32'h00000000});
    issue("R2 busy", 6'd7, 3'd1, 1, 0, 0, 5'd4, {96'h0, 32'h00000080});
    issue("R3 short normal", 6'd9, 3'd1, 0, 0, 0, 5'd3, {96'h0, 32'h000000FF});
    issue("R3 short long", 6'd2, 3'd2, 0, 0, 0, 5'd15, ~pat);
    issue("R3 full long", 6'd2, 3'd2, 0, 0, 0, 5'd16, ~pat);
    issue("R4 auth off", 6'd13, 3'd1, 0, 0, 0, 5'd4, {96'h0, 32'h08000000});
    issue("R4 auth on", 6'd13, 3'd1, 0, 0, 1, 5'd4, {96'h0, 32'h08000000});
    issue("R5 ocr busy", 6'd41, 3'd3, 0, 0, 0, 5'd4, {96'h0, 32'h00000000});
    issue("R5 ocr ready", 6'd41, 3'd3, 0, 0, 0, 5'd4, {96'h0, 32'h00000080});
    issue("R6 rca err", 6'd3, 3'd4, 0, 0, 0, 5'd4, {96'h0, 32'h00200000});
    issue("R6 rca ignores b0", 6'd3, 3'd4, 0, 0, 0, 5'd4, {96'h0, 32'h000000FF});
    issue("R9 stop", 6'd12, 3'd1, 1, 0, 0, 5'd4, pat);
    issue("R10 none", 6'd0, 3'd0, 0, 0, 0, 5'd0, ~pat);
    issue("R10 none code7", 6'd8, 3'd7, 0, 0, 0, 5'd16, 128'h1);
    for (int i = 0; i < 400; i++) begin
      logic [127:0] b;
      b = {$urandom, $urandom, $urandom, $urandom};
      issue("R7 random", 6'($urandom_range(0, 15)), 3'($urandom_range(0, 7)),
            1'($urandom), 1'($urandom_range(0, 4) == 0), 1'($urandom),
            5'($urandom_range(0, 16)), b);
    end
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule